// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master reach a 256-location byte register space inside the device. The master addresses the slave, sends one byte that loads an internal location pointer, and then either writes data bytes starting at that location or issues a repeated START and reads bytes back from it. After every byte the pointer moves to the next location, so a burst touches consecutive locations and wraps from FFh to 00h.

Toward the rest of the device the block has a simple register-file port. It drives a location address, a single-cycle write strobe with write data, and it takes read data combinationally for the location it addresses. Each location carries an access class that is decoded from fixed address ranges. Status locations can only be read. Configuration locations can be read and written. Every other location is unused: it reads as zero and ignores writes. A strap input chooses one of two 7-bit device addresses. SCL and SDA are oversampled on the system clock, which must run at least 20 times faster than SCL. This is enough for 400 kbit/s operation.

Top module: `i2c_regacc_slave`

## Requirements
- R1: With `addr_strap_i` low, the slave responds only to device address 0100101 (address bytes 4Ah write, 4Bh read). With it high, it responds only to 0100100 (48h/49h). On any other address it does not acknowledge and leaves SDA released until the next START.
- R2: The slave pulls SDA low during the acknowledge clock after a matching address byte, after the pointer byte and after every data byte the master writes. This includes writes to read-only and unused locations.
- R3: In a write transfer the byte after the address loads the pointer. Each following byte produces exactly one single-cycle `reg_wr_en_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wr_data_o` equal to the byte.
- R4: The pointer advances by one after every data byte written or read, and it wraps from FFh to 00h.
- R5: In a combined read (START, address+W, pointer byte, repeated START, address+R), the slave sends the byte at the pointer MSB first. It sends the next location's byte for every byte the master acknowledges.
- R6: Locations 00h, 1Fh and 60h-62h are read-only. Writes to them are acknowledged but raise no write strobe. Reads return `reg_rd_data_i`.
- R7: Locations 14h, 18h-1Eh, 20h-3Fh, 5Fh and 63h-FFh are unused. Writes to them raise no write strobe, and reads return 00h whatever `reg_rd_data_i` holds. Locations 01h-13h, 15h-17h and 40h-5Eh are read/write.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START or STOP.
- R9: A STOP returns the slave to idle with SDA released. Bytes clocked without a fresh START are not acknowledged. A repeated START restarts address reception.
- R10: After reset SDA is released and no write strobe is active.
- R11: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_strap_i | input | 1 | Device address select: 0 gives 0100101, 1 gives 0100100 |
| reg_addr_o | output | 8 | Register location being read or written |
| reg_wr_en_o | output | 1 | Single-cycle write strobe |
| reg_wr_data_o | output | 8 | Write data, valid with the strobe |
| reg_rd_data_i | input | 8 | Read data for `reg_addr_o` |

## Verification
The bench targets the pointer at its edges. A burst read starting at FFh must return 00h (unused) followed by location 00h, which fails if the pointer saturates or if the unused mask is applied to the wrong location. Writes aimed at read-only and unused locations are checked in the register file behind the port: a decoder with a wrong range boundary would corrupt a status byte there, or it would refuse to acknowledge the write. After a master NACK the bench clocks an extra byte and expects all ones, which catches a slave that keeps driving data. A foreign address, the other strap setting, and bytes sent after a STOP without a START must all go unacknowledged; a slave that decodes the address loosely or does not return to idle would answer them.

// File: rtl/i2c_regacc_pkg.sv
package i2c_regacc_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {
        ACC_RSV = 2'd0,
        ACC_RO  = 2'd1,
        ACC_RW  = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_SUB    = 3'd2,
        ST_WDATA  = 3'd3,
        ST_ACK    = 3'd4,
        ST_TX     = 3'd5,
        ST_MACK   = 3'd6,
        ST_IGNORE = 3'd7
    } st_e;

    typedef struct packed {
        st_e               st;
        st_e               nxt;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr;
        logic              sda_oe;
        logic              mack;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } eng_s;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [CHAIN_W-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/i2c_access_map.sv
module i2c_access_map
    import i2c_regacc_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_i,
    output acc_e              acc_o
);

    localparam int NRANGE = 6;
    localparam logic [BYTE_W-1:0] LO   [NRANGE] = '{8'h00, 8'h1F, 8'h60, 8'h01, 8'h15, 8'h40};
    localparam logic [BYTE_W-1:0] SPAN [NRANGE] = '{8'h00, 8'h00, 8'h02, 8'h12, 8'h02, 8'h1E};
    localparam logic [NRANGE-1:0] RW_MASK = 6'b111000;

    logic [NRANGE-1:0] hit;

    for (genvar g = 0; g < NRANGE; g++) begin : g_range
        logic [BYTE_W-1:0] off;
        assign off    = addr_i - LO[g];
        assign hit[g] = (off <= SPAN[g]);
    end

    always_comb begin
        acc_o = ACC_RSV;
        for (int i = 0; i < NRANGE; i++) begin
            if (hit[i]) acc_o = RW_MASK[i] ? ACC_RW : ACC_RO;
        end
    end

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
    import i2c_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [6:0]        dev_addr,
    input  logic              can_write,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr
);

    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    eng_s q, d;
    logic start_c, stop_c;

    assign start_c = sda_fall & scl;
    assign stop_c  = sda_rise & scl;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start_c) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
        end else if (stop_c) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise && q.cnt < LAST_RX) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_RX) begin
                        d.sda_oe = 1'b1;
                        d.st     = ST_ACK;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[BYTE_W-1:1] == dev_addr) begin
                                d.nxt = q.sh[0] ? ST_TX : ST_SUB;
                            end else begin
                                d.sda_oe = 1'b0;
                                d.st     = ST_IGNORE;
                            end
                        end else if (q.st == ST_SUB) begin
                            d.ptr = q.sh;
                            d.nxt = ST_WDATA;
                        end else begin
                            d.nxt = ST_WDATA;
                            d.ptr = q.ptr + 1'b1;
                            if (can_write) begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.ptr;
                                d.wr_data = q.sh;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.nxt == ST_TX) begin
                            d.sh     = rd_byte;
                            d.ptr    = q.ptr + 1'b1;
                            d.sda_oe = ~rd_byte[BYTE_W-1];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = q.nxt;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_TX) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_MACK;
                        end else begin
                            d.sh     = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt    = q.cnt + 1'b1;
                            d.sda_oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.sh     = rd_byte;
                            d.ptr    = q.ptr + 1'b1;
                            d.sda_oe = ~rd_byte[BYTE_W-1];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    d.sda_oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, cnt: '0, sh: '0, ptr: '0,
                   sda_oe: 1'b0, mack: 1'b0, wr_en: 1'b0, wr_addr: '0, wr_data: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.sda_oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign ptr     = q.ptr;

    // R11
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sda_oe != $past(q.sda_oe)) |-> !scl);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (q.st == ST_IDLE && !q.sda_oe));

    // R1
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !q.sda_oe);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.ptr == q.wr_addr + 1'b1));

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |=> !q.wr_en);

    // R8
    mnack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MACK && scl_fall && !q.mack && !start_c && !stop_c)
        |=> (q.st == ST_IGNORE && !q.sda_oe));

endmodule

// File: rtl/i2c_regacc_slave.sv
module i2c_regacc_slave
    import i2c_regacc_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'b0100101,
    parameter logic [6:0] ADDR_STRAP  = 7'b0100100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              addr_strap_i,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic              reg_wr_en_o,
    output logic [BYTE_W-1:0] reg_wr_data_o,
    input  logic [BYTE_W-1:0] reg_rd_data_i
);

    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [1:0]        lvl, rise, fall;
    logic [6:0]        dev_addr;
    acc_e              acc;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr, ptr, rd_byte;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sda_i, scl_i}),
        .lvl_o (lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    assign dev_addr   = addr_strap_i ? ADDR_STRAP : ADDR_BASE;
    assign reg_addr_o = wr_en ? wr_addr : ptr;

    i2c_access_map u_map (
        .addr_i(reg_addr_o),
        .acc_o (acc)
    );

    assign rd_byte = (acc == ACC_RSV) ? '0 : reg_rd_data_i;

    i2c_slave_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (lvl[IDX_SCL]),
        .scl_rise (rise[IDX_SCL]),
        .scl_fall (fall[IDX_SCL]),
        .sda      (lvl[IDX_SDA]),
        .sda_rise (rise[IDX_SDA]),
        .sda_fall (fall[IDX_SDA]),
        .dev_addr (dev_addr),
        .can_write(acc == ACC_RW),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe_o),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (reg_wr_data_o),
        .ptr      (ptr)
    );

    assign reg_wr_en_o = wr_en;

    // R6 R7
    rw_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en_o |-> (acc == ACC_RW));

endmodule

// File: tb/i2c_regacc_slave_tb.sv
module i2c_regacc_slave_tb;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_oe;
    logic       sda_bus;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic [7:0] regs [256];
    logic [7:0] exp_mem [256];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    int         nchk = 0;
    int         nfail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    function automatic logic [7:0] init_val(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
        end
    end

    i2c_regacc_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .addr_strap_i (strap),
        .reg_addr_o   (reg_addr),
        .reg_wr_en_o  (reg_we),
        .reg_wr_data_o(reg_wdata),
        .reg_rd_data_i(reg_rdata)
    );

    function automatic bit is_rw(logic [7:0] a);
        return (a >= 8'h01 && a <= 8'h13) || (a >= 8'h15 && a <= 8'h17) ||
               (a >= 8'h40 && a <= 8'h5E);
    endfunction

    function automatic bit is_ro(logic [7:0] a);
        return (a == 8'h00) || (a == 8'h1F) || (a >= 8'h60 && a <= 8'h62);
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        return (is_rw(a) || is_ro(a)) ? exp_mem[a] : 8'h00;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl = 1'b0; qw();
    endtask

    task automatic i2c_rstart();
        sda_m = 1'b1; qw();
        scl = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qw();
        scl = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl = 1'b1; qw(); qw();
            scl = 1'b0; qw();
        end
        sda_m = 1'b1; qw();
        scl = 1'b1; qw();
        ack = ~sda_bus; qw();
        scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qw();
            scl = 1'b1; qw();
            b = {b[6:0], sda_bus}; qw();
            scl = 1'b0;
        end
        qw();
        sda_m = ~mack; qw();
        scl = 1'b1; qw(); qw();
        scl = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] devw, input logic [7:0] sub, input int n,
                            input string tag);
        logic ack;
        i2c_start();
        send_byte(devw, ack);
        chk({tag, " R2 addr ack"}, ack, 1);
        send_byte(sub, ack);
        chk({tag, " R2 sub ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk({tag, " R2 data ack"}, ack, 1);
            if (is_rw(sub + 8'(i))) exp_mem[sub + 8'(i)] = wbuf[i];
        end
        i2c_stop();
        qw();
    endtask

    task automatic do_read(input logic [7:0] devw, input logic [7:0] sub, input int n,
                           input string tag);
        logic ack;
        i2c_start();
        send_byte(devw, ack);
        chk({tag, " R2 addr ack"}, ack, 1);
        send_byte(sub, ack);
        chk({tag, " R2 sub ack"}, ack, 1);
        i2c_rstart();
        send_byte(devw | 8'h01, ack);
        chk({tag, " R9 rstart addr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, rbuf[i]);
            chk({tag, " R5 read data"}, rbuf[i], exp_rd(sub + 8'(i)));
        end
        i2c_stop();
        qw();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (10) @(negedge clk);
        // R10: reset state
        chk("R10 sda released in reset", sda_oe, 0);
        chk("R10 no strobe in reset", reg_we, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 sda released after reset", sda_oe, 0);

        // R3: single write to a read/write location
        wbuf[0] = 8'hA5;
        do_write(8'h4A, 8'h01, 1, "R3 single");
        chk("R3 written value", regs[8'h01], 8'hA5);

        // R4: burst write with auto-increment
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i * 3);
        do_write(8'h4A, 8'h40, 4, "R4 burst");
        for (int i = 0; i < 4; i++) chk("R4 burst location", regs[8'h40 + 8'(i)], exp_mem[8'h40 + 8'(i)]);

        // R6 R7: writes to read-only and unused locations
        wbuf[0] = 8'hFF;
        do_write(8'h4A, 8'h00, 1, "R6 ro 00");
        do_write(8'h4A, 8'h1F, 1, "R6 ro 1F");
        do_write(8'h4A, 8'h61, 1, "R6 ro 61");
        do_write(8'h4A, 8'h14, 1, "R7 rsv 14");
        do_write(8'h4A, 8'h5F, 1, "R7 rsv 5F");
        chk("R6 ro 00 kept", regs[8'h00], init_val(8'h00));
        chk("R6 ro 1F kept", regs[8'h1F], init_val(8'h1F));
        chk("R6 ro 61 kept", regs[8'h61], init_val(8'h61));
        chk("R7 rsv 14 kept", regs[8'h14], init_val(8'h14));
        chk("R7 rsv 5F kept", regs[8'h5F], init_val(8'h5F));

        // R5: combined read burst
        do_read(8'h4A, 8'h40, 4, "R5 burst");
        // R6: read-only location reads port data
        do_read(8'h4A, 8'h60, 3, "R6 ro read");
        // R7: unused location reads zero
        do_read(8'h4A, 8'h5F, 1, "R7 rsv read");
        // R4: wrap FF -> 00
        do_read(8'h4A, 8'hFF, 2, "R4 wrap");
        chk("R4 wrap second byte", rbuf[1], init_val(0));

        // R1: foreign address ignored until next START
        i2c_start();
        send_byte(8'h42, ack);
        chk("R1 foreign addr nack", ack, 0);
        send_byte(8'h01, ack);
        chk("R1 no ack after mismatch", ack, 0);
        send_byte(8'h99, ack);
        chk("R1 still no ack", ack, 0);
        i2c_stop();
        qw();
        chk("R1 location untouched", regs[8'h01], exp_mem[8'h01]);

        // R1: strap selects the other address
        strap = 1'b1;
        qw();
        i2c_start();
        send_byte(8'h4A, ack);
        chk("R1 default addr refused when strapped", ack, 0);
        i2c_stop();
        qw();
        wbuf[0] = 8'h3C;
        do_write(8'h48, 8'h02, 1, "R1 strapped write");
        chk("R1 strapped write value", regs[8'h02], 8'h3C);
        do_read(8'h48, 8'h02, 1, "R1 strapped read");
        strap = 1'b0;
        qw();

        // R8: master NACK stops transmission
        i2c_start();
        send_byte(8'h4A, ack);
        send_byte(8'h02, ack);
        i2c_rstart();
        send_byte(8'h4B, ack);
        recv_byte(1'b0, b);
        chk("R8 byte before nack", b, exp_rd(8'h02));
        recv_byte(1'b0, b);
        chk("R8 bus released after nack", b, 8'hFF);
        i2c_stop();
        qw();

        // R9: after STOP, bytes without START are not acknowledged
        chk("R9 idle after stop", sda_oe, 0);
        send_byte(8'h4A, ack);
        chk("R9 no ack without start", ack, 0);
        scl = 1'b1; qw();
        sda_m = 1'b0; qw();
        sda_m = 1'b1; qw();

        // R11 R3 R5: random write/read-back traffic
        for (int t = 0; t < 16; t++) begin
            logic [7:0] sub;
            int n;
            sub = 8'($urandom % 256);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(8'h4A, sub, n, "R3 random");
            do_read(8'h4A, sub, n, "R5 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule